// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block is a synchronous state machine that follows the operating mode of a small processor and turns that mode into clock enables. It leaves reset through a short boot count and then runs. Single-cycle pulses report that the processor has executed its halt or sleep instruction, that a wake-up (cancel) event arrived, that a debug interrupt was taken, or that the debug handler returned. The controller answers with a 3-bit mode code, a processor clock enable, a peripheral clock enable and one enable for each of three oscillators: internal, high-speed and external.

A 2-bit register selects the system clock source. In run and halt only the selected oscillator is enabled. In sleep each oscillator has its own stop bit. A source whose stop bit is 0 keeps running, and peripherals keep their clock when the selected source is one of those. The controller never drives a reset or a clear toward storage, so memory contents survive sleep. Debug remembers the state it interrupted and returns to that state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstReq` is high the mode is 0 (reset), `cpuClkEn` and `periClkEn` are 0, `oscEn` is 3'b001 and `sysSrc` is 0. After `rstReq` falls the mode becomes 1 (run) on exactly the BOOT_CYCLES-th rising clock edge.
- R2: A halt pulse in run moves the mode to 2 (halt). There `cpuClkEn` is 0, `periClkEn` is 1 and `oscEn` enables only the selected source.
- R3: A sleep pulse in run moves the mode to 3 (sleep). There `oscEn[i]` equals the inverse of `slpStop[i]` (bit 0 internal, bit 1 high-speed, bit 2 external), `cpuClkEn` is 0, and `periClkEn` is the inverse of the stop bit of the selected source.
- R4: A wake pulse in halt or sleep returns the mode to 1 (run).
- R5: A debug interrupt in run, halt or sleep moves the mode to 4 (debug), where both the processor and peripheral clock enables are 1. A debug-return pulse in debug restores the state that was active at entry.
- R6: The source code is 0 internal, 2 high-speed, 3 external. A write (`srcWr` high) updates `sysSrc` on the next edge only in run. A write of the reserved code 1, or a write in any other state, leaves `sysSrc` unchanged.
- R7: In run, `oscEn` has exactly one bit set: bit 0 for source 0, bit 1 for source 2, bit 2 for source 3. `cpuClkEn` and `periClkEn` are both 1.
- R8: Priority is debug interrupt first, then wake, then halt, then sleep. In run, a wake pulse arriving with a halt or sleep pulse cancels the entry and the mode stays run. A halt and a sleep pulse together enter halt. A debug interrupt arriving with a wake pulse in halt enters debug.
- R9: `cpuClkEn`, `periClkEn` and `oscEn` are registered. They take the values of a new mode one clock edge after `mode` changes.
- R10: Pulses that do not apply in the current state are ignored. This covers halt or sleep pulses in halt or sleep, debug return outside debug, and a debug interrupt while already in debug. In the last case the saved state is also unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstReq | input | 1 | Reset request, active high, asynchronous assert |
| haltPulse | input | 1 | Halt instruction executed |
| sleepPulse | input | 1 | Sleep instruction executed |
| wakePulse | input | 1 | Halt/sleep cancel (wake-up) event |
| dbgIrq | input | 1 | Debug interrupt |
| dbgRet | input | 1 | Return from debug handler |
| srcWr | input | 1 | Clock source select write strobe |
| srcSel | input | 2 | Requested system clock source |
| slpStop | input | 3 | Per-oscillator stop-in-sleep bits (0 keeps it running) |
| mode | output | 3 | Mode code: 0 reset, 1 run, 2 halt, 3 sleep, 4 debug |
| sysSrc | output | 2 | Active system clock source |
| cpuClkEn | output | 1 | Processor clock enable |
| periClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 3 | Oscillator enables: internal, high-speed, external |

## Verification
The bench builds the block with its default boot length of 4 cycles. This is short enough that reset release and the exact boot edge can be observed cycle by cycle. With only three legal sources and three stop bits, every pair of source and stop-bit pattern (24 cases) goes through a sleep entry, and every source goes through halt. Debug is entered from each of the three resumable states, and each return target is checked. Simultaneous pulses are applied in run, halt and sleep to cover the priority order.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int OSC_N = 3;
  localparam int SRC_W = 2;

  localparam logic [SRC_W-1:0] SRC_INT = 2'd0;
  localparam logic [SRC_W-1:0] SRC_RSV = 2'd1;
  localparam logic [SRC_W-1:0] SRC_HS  = 2'd2;
  localparam logic [SRC_W-1:0] SRC_EXT = 2'd3;

  typedef enum logic [2:0] {
    MD_RESET = 3'd0,
    MD_RUN   = 3'd1,
    MD_HALT  = 3'd2,
    MD_SLEEP = 3'd3,
    MD_DEBUG = 3'd4
  } pmc_mode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic bootInc;
    logic saveState;
    logic srcLoad;
  } pmc_strobe_t;

  function automatic logic [OSC_N-1:0] srcToOneHot(input logic [SRC_W-1:0] src);
    case (src)
      SRC_HS:  return 3'b010;
      SRC_EXT: return 3'b100;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic [1:0] srcToIdx(input logic [SRC_W-1:0] src);
    case (src)
      SRC_HS:  return 2'd1;
      SRC_EXT: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic        clk,
  input  logic        rstReq,
  input  logic        haltPulse,
  input  logic        sleepPulse,
  input  logic        wakePulse,
  input  logic        dbgIrq,
  input  logic        dbgRet,
  input  logic        srcWr,
  input  logic [SRC_W-1:0] srcSel,
  input  logic        bootDone,
  input  pmc_mode_e   savedState,
  output pmc_mode_e   state,
  output pmc_strobe_t strobe
);

  pmc_mode_e nextSt;

  always_comb begin
    nextSt = state;
    strobe = '0;
    case (state)
      MD_RESET: begin
        strobe.bootInc = 1'b1;
        if (bootDone) nextSt = MD_RUN;
      end
      MD_RUN: begin
        strobe.srcLoad = srcWr && (srcSel != SRC_RSV);
        if (dbgIrq) begin
          nextSt = MD_DEBUG;
          strobe.saveState = 1'b1;
        end else if (wakePulse) begin
          nextSt = MD_RUN;
        end else if (haltPulse) begin
          nextSt = MD_HALT;
        end else if (sleepPulse) begin
          nextSt = MD_SLEEP;
        end
      end
      MD_HALT, MD_SLEEP: begin
        if (dbgIrq) begin
          nextSt = MD_DEBUG;
          strobe.saveState = 1'b1;
        end else if (wakePulse) begin
          nextSt = MD_RUN;
        end
      end
      MD_DEBUG: begin
        if (dbgRet) nextSt = savedState;
      end
      default: nextSt = MD_RESET;
    endcase
  end

  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq) state <= MD_RESET;
    else        state <= nextSt;
  end

  p_halt_entry_r2: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_RUN && haltPulse && !dbgIrq && !wakePulse) |=> state == MD_HALT);

  p_sleep_entry_r3: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_RUN && sleepPulse && !haltPulse && !dbgIrq && !wakePulse) |=> state == MD_SLEEP);

  p_wake_r4: assert property (@(posedge clk) disable iff (rstReq)
    ((state == MD_HALT || state == MD_SLEEP) && wakePulse && !dbgIrq) |=> state == MD_RUN);

  p_debug_entry_r5: assert property (@(posedge clk) disable iff (rstReq)
    ((state == MD_RUN || state == MD_HALT || state == MD_SLEEP) && dbgIrq) |=> state == MD_DEBUG);

  p_debug_return_r5: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_DEBUG && dbgRet) |=> state == $past(savedState));

  p_wake_cancels_r8: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_RUN && wakePulse && !dbgIrq) |=> state == MD_RUN);

  p_debug_stays_r10: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_DEBUG && !dbgRet) |=> state == MD_DEBUG);

endmodule

// File: rtl/pmc_dpath.sv
module pmc_dpath
  import pmc_pkg::*;
#(
  parameter int BOOT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstReq,
  input  pmc_mode_e         state,
  input  pmc_strobe_t       strobe,
  input  logic [SRC_W-1:0]  srcSel,
  input  logic [OSC_N-1:0]  slpStop,
  output logic              bootDone,
  output pmc_mode_e         savedState,
  output logic [SRC_W-1:0]  srcReg,
  output logic              cpuClkEn,
  output logic              periClkEn,
  output logic [OSC_N-1:0]  oscEn
);

  localparam int CNT_W = $clog2(BOOT_CYCLES) + 1;

  logic [CNT_W-1:0] bootCnt;
  logic [OSC_N-1:0] oscEnD;
  logic             cpuEnD;
  logic             periEnD;

  // boot sequence counter
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)              bootCnt <= '0;
    else if (strobe.bootInc) bootCnt <= bootCnt + 1'b1;
  end
  assign bootDone = (bootCnt == CNT_W'(BOOT_CYCLES - 1));

  // system clock source register
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)             srcReg <= SRC_INT;
    else if (strobe.srcLoad) srcReg <= srcSel;
  end

  // state saved on debug entry
  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq)                savedState <= MD_RUN;
    else if (strobe.saveState) savedState <= state;
  end

  // enable decode
  always_comb begin
    oscEnD  = srcToOneHot(srcReg);
    cpuEnD  = 1'b0;
    periEnD = 1'b0;
    case (state)
      MD_RESET: oscEnD = srcToOneHot(SRC_INT);
      MD_RUN, MD_DEBUG: begin
        cpuEnD  = 1'b1;
        periEnD = 1'b1;
      end
      MD_HALT: periEnD = 1'b1;
      MD_SLEEP: begin
        oscEnD  = ~slpStop;
        periEnD = ~slpStop[srcToIdx(srcReg)];
      end
      default: oscEnD = srcToOneHot(SRC_INT);
    endcase
  end

  generate
    for (genvar g = 0; g < OSC_N; g++) begin : g_osc
      always_ff @(posedge clk or posedge rstReq) begin
        if (rstReq) oscEn[g] <= (g == 0);
        else        oscEn[g] <= oscEnD[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge rstReq) begin
    if (rstReq) begin
      cpuClkEn  <= 1'b0;
      periClkEn <= 1'b0;
    end else begin
      cpuClkEn  <= cpuEnD;
      periClkEn <= periEnD;
    end
  end

  p_src_hold_r6: assert property (@(posedge clk) disable iff (rstReq)
    !(state == MD_RUN && srcSel != SRC_RSV) |=> $stable(srcReg));

  p_src_legal_r6: assert property (@(posedge clk) disable iff (rstReq)
    srcReg != SRC_RSV);

  p_run_onehot_r7: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_RUN) |=> ($countones(oscEn) == 1 && cpuClkEn && periClkEn));

  p_halt_cpu_off_r2: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_HALT) |=> (!cpuClkEn && periClkEn));

  p_sleep_osc_r3: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_SLEEP) |=> (oscEn == ~$past(slpStop) && !cpuClkEn));

  p_debug_clk_r5: assert property (@(posedge clk) disable iff (rstReq)
    (state == MD_DEBUG) |=> (cpuClkEn && periClkEn));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int BOOT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstReq,
  input  logic       haltPulse,
  input  logic       sleepPulse,
  input  logic       wakePulse,
  input  logic       dbgIrq,
  input  logic       dbgRet,
  input  logic       srcWr,
  input  logic [1:0] srcSel,
  input  logic [2:0] slpStop,
  output logic [2:0] mode,
  output logic [1:0] sysSrc,
  output logic       cpuClkEn,
  output logic       periClkEn,
  output logic [2:0] oscEn
);

  pmc_mode_e   state;
  pmc_mode_e   savedState;
  pmc_strobe_t strobe;
  logic        bootDone;

  pmc_ctrl u_ctrl (
    .clk        (clk),
    .rstReq     (rstReq),
    .haltPulse  (haltPulse),
    .sleepPulse (sleepPulse),
    .wakePulse  (wakePulse),
    .dbgIrq     (dbgIrq),
    .dbgRet     (dbgRet),
    .srcWr      (srcWr),
    .srcSel     (srcSel),
    .bootDone   (bootDone),
    .savedState (savedState),
    .state      (state),
    .strobe     (strobe)
  );

  pmc_dpath #(.BOOT_CYCLES(BOOT_CYCLES)) u_dpath (
    .clk        (clk),
    .rstReq     (rstReq),
    .state      (state),
    .strobe     (strobe),
    .srcSel     (srcSel),
    .slpStop    (slpStop),
    .bootDone   (bootDone),
    .savedState (savedState),
    .srcReg     (sysSrc),
    .cpuClkEn   (cpuClkEn),
    .periClkEn  (periClkEn),
    .oscEn      (oscEn)
  );

  assign mode = state;

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BOOT = 4;

  logic clk = 1'b0;
  logic rstReq = 1'b1;
  logic haltPulse = 1'b0, sleepPulse = 1'b0, wakePulse = 1'b0;
  logic dbgIrq = 1'b0, dbgRet = 1'b0, srcWr = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic [2:0] slpStop = 3'b111;
  logic [2:0] mode;
  logic [1:0] sysSrc;
  logic cpuClkEn, periClkEn;
  logic [2:0] oscEn;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.BOOT_CYCLES(BOOT)) u_dut (
    .clk(clk), .rstReq(rstReq), .haltPulse(haltPulse), .sleepPulse(sleepPulse),
    .wakePulse(wakePulse), .dbgIrq(dbgIrq), .dbgRet(dbgRet), .srcWr(srcWr),
    .srcSel(srcSel), .slpStop(slpStop), .mode(mode), .sysSrc(sysSrc),
    .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .oscEn(oscEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clrPulses();
    haltPulse = 0; sleepPulse = 0; wakePulse = 0;
    dbgIrq = 0; dbgRet = 0; srcWr = 0;
  endtask

  function automatic int oneHot(input int s);
    return 1 << ((s == 0) ? 0 : s - 1);
  endfunction

  task automatic setSrc(input int s);
    srcWr = 1; srcSel = 2'(s);
    step();
    clrPulses();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    int curSrc;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", mode, 0);
    chk("R1 cpu in reset", cpuClkEn, 0);
    chk("R1 peri in reset", periClkEn, 0);
    chk("R1 osc in reset", oscEn, 1);
    chk("R1 src in reset", sysSrc, 0);
    rstReq = 0;
    repeat (BOOT - 1) step();
    chk("R1 still booting", mode, 0);
    step();
    chk("R1 run after boot", mode, 1);
    chk("R9 cpu lags mode", cpuClkEn, 0);
    step();
    chk("R7 cpu in run", cpuClkEn, 1);
    chk("R7 peri in run", periClkEn, 1);
    chk("R7 osc in run", oscEn, 1);

    // R6 source select sweep
    curSrc = 0;
    for (int s = 0; s < 4; s++) begin
      setSrc(s);
      if (s != 1) curSrc = s;
      chk("R6 sysSrc after write", sysSrc, curSrc);
      step();
      chk("R7 osc follows src", oscEn, oneHot(curSrc));
    end
    setSrc(1);
    chk("R6 reserved ignored", sysSrc, 3);

    // R2 halt per source, R4 wake
    for (int k = 0; k < 3; k++) begin
      int s;
      s = (k == 0) ? 0 : k + 1;
      setSrc(s);
      haltPulse = 1; step(); clrPulses();
      chk("R2 halt mode", mode, 2);
      step();
      chk("R2 cpu off in halt", cpuClkEn, 0);
      chk("R2 peri on in halt", periClkEn, 1);
      chk("R2 osc in halt", oscEn, oneHot(s));
      srcWr = 1; srcSel = (s == 0) ? 2'd3 : 2'd0; step(); clrPulses();
      chk("R6 write in halt ignored", sysSrc, s);
      haltPulse = 1; sleepPulse = 1; step(); clrPulses();
      chk("R10 halt/sleep in halt ignored", mode, 2);
      wakePulse = 1; step(); clrPulses();
      chk("R4 wake from halt", mode, 1);
      step();
    end

    // R3 sleep sweep over source and stop bits
    for (int k = 0; k < 3; k++) begin
      int s;
      s = (k == 0) ? 0 : k + 1;
      setSrc(s);
      for (int ss = 0; ss < 8; ss++) begin
        slpStop = 3'(ss);
        sleepPulse = 1; step(); clrPulses();
        chk("R3 sleep mode", mode, 3);
        step();
        chk("R3 osc in sleep", oscEn, (~ss) & 7);
        chk("R3 peri in sleep", periClkEn, ((ss >> ((s == 0) ? 0 : s - 1)) & 1) ^ 1);
        chk("R3 cpu off in sleep", cpuClkEn, 0);
        wakePulse = 1; step(); clrPulses();
        chk("R4 wake from sleep", mode, 1);
        step();
        chk("R9 run osc after sleep", oscEn, oneHot(s));
      end
    end
    slpStop = 3'b111;

    // R5 debug from run, halt, sleep
    dbgIrq = 1; step(); clrPulses();
    chk("R5 debug from run", mode, 4);
    step();
    chk("R5 cpu in debug", cpuClkEn, 1);
    chk("R5 peri in debug", periClkEn, 1);
    dbgIrq = 1; haltPulse = 1; step(); clrPulses();
    chk("R10 irq in debug ignored", mode, 4);
    dbgRet = 1; step(); clrPulses();
    chk("R5 return to run", mode, 1);
    dbgRet = 1; step(); clrPulses();
    chk("R10 ret in run ignored", mode, 1);

    haltPulse = 1; step(); clrPulses();
    dbgIrq = 1; wakePulse = 1; step(); clrPulses();
    chk("R8 debug beats wake", mode, 4);
    dbgRet = 1; step(); clrPulses();
    chk("R5 return to halt", mode, 2);
    wakePulse = 1; step(); clrPulses();

    sleepPulse = 1; step(); clrPulses();
    dbgIrq = 1; step(); clrPulses();
    chk("R5 debug from sleep", mode, 4);
    dbgRet = 1; step(); clrPulses();
    chk("R5 return to sleep", mode, 3);
    haltPulse = 1; step(); clrPulses();
    chk("R10 halt in sleep ignored", mode, 3);
    wakePulse = 1; step(); clrPulses();

    // R8 priorities in run
    wakePulse = 1; haltPulse = 1; step(); clrPulses();
    chk("R8 wake cancels halt", mode, 1);
    wakePulse = 1; sleepPulse = 1; step(); clrPulses();
    chk("R8 wake cancels sleep", mode, 1);
    haltPulse = 1; sleepPulse = 1; step(); clrPulses();
    chk("R8 halt beats sleep", mode, 2);
    wakePulse = 1; step(); clrPulses();
    dbgIrq = 1; haltPulse = 1; step(); clrPulses();
    chk("R8 debug beats halt", mode, 4);
    dbgRet = 1; step(); clrPulses();
    chk("R5 return run after priority", mode, 1);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule